// File: doc/BRIEF.md
# Presettable Up/Down Counter with Carries

This block is a small synchronous counter that can be preset from a data bus, stepped up or down, and cleared either at once or on the next clock edge. A parameter chooses between a full binary range (modulo 16 for the default width) and a decade range (modulo 10). All synchronous actions take place on the rising clock edge.

Two active-low carry outputs let several units form a longer counter. The ripple carry follows the present count, the direction and the T enable. The clocked carry is also gated by the low half of the clock, so it only pulses after the count has settled. The count is always presented on a data bus. The three-state drive of a discrete output stage is modelled as a separate drive-enable flag. Counting continues whatever that flag shows.

Top module: `updown_counter4`

## Requirements
- R1: While `arst_n` is low the count is 0 at once, with no clock edge needed, whatever the other inputs are.
- R2: If `sclr_n` is low at a rising edge, the count becomes 0. This takes priority over load and counting.
- R3: If `sclr_n` is high and `load_n` is low at a rising edge, the count takes the value of `din`. This takes priority over counting.
- R4: The count changes by one step only when `enp_n` and `ent_n` are both low and `sclr_n` and `load_n` are both high. Otherwise the count holds its value.
- R5: With `up` = 1 each step adds one, and with `up` = 0 each step subtracts one. In binary mode the count wraps from 15 to 0 going up and from 0 to 15 going down.
- R6: In decade mode the count wraps from 9 to 0 going up and from 0 to 9 going down.
- R7: In decade mode a loaded value from 10 to 15 is kept. The next up step from such a value gives 0, and the next down step gives that value minus one.
- R8: `rco_n` is low exactly when `ent_n` is low and the count is at its terminal value. The terminal value is 0 when `up` = 0, and the maximum (15 binary, 9 decade) when `up` = 1.
- R9: `cco_n` is low exactly when `clk` is low, `rco_n` is low and `enp_n` is low. Otherwise it is high.
- R10: `q_oe` equals the inverse of `oe_n`. `q` always carries the count, and counting is not affected by `oe_n`.
- R11: Two binary units form an 8-bit counter when the `rco_n` of the low unit drives the `ent_n` of the high unit. The 8-bit counter steps and wraps correctly in both directions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; rising edge is active |
| arst_n | input | 1 | Immediate clear, active low |
| sclr_n | input | 1 | Clear on next edge, active low |
| load_n | input | 1 | Preset from `din` on next edge, active low |
| din | input | WIDTH | Preset value |
| enp_n | input | 1 | Count enable P, active low |
| ent_n | input | 1 | Count enable T, active low; also qualifies the ripple carry |
| up | input | 1 | Direction: 1 counts up, 0 counts down |
| oe_n | input | 1 | Output drive enable, active low |
| q | output | WIDTH | Present count |
| q_oe | output | 1 | High when `q` would be driven onto a shared bus |
| rco_n | output | 1 | Ripple carry, active low |
| cco_n | output | 1 | Clocked carry, active low during the clock low phase |

## Verification
The counting path is driven with each control input taking priority in turn over the ones below it: immediate clear against a pending load, clear on edge against load with enables active, load against count, and each enable alone. This shows that every control has the right priority. Up and down runs cross the wrap point in the binary unit and in a decade unit, and a decade unit is preset to values above nine. These runs separate a design that wraps on equality from one that wraps on the modulus. The carries are sampled in both clock phases, with each enable removed on its own, at both terminal values and in both directions. A cascaded pair is run across the 8-bit wrap in both directions, which shows whether the ripple carry ends up on the correct unit.

// File: rtl/ctr_pkg.sv
package ctr_pkg;
    typedef enum logic [2:0] {
        OP_HOLD  = 3'd0,
        OP_CLEAR = 3'd1,
        OP_LOAD  = 3'd2,
        OP_INC   = 3'd3,
        OP_DEC   = 3'd4
    } ctr_op_e;
endpackage

// File: rtl/ctr_ctrl.sv
module ctr_ctrl
    import ctr_pkg::*;
(
    input  logic    sclr_n,
    input  logic    load_n,
    input  logic    enp_n,
    input  logic    ent_n,
    input  logic    up,
    output ctr_op_e op
);
    always_comb begin
        if (!sclr_n)                op = OP_CLEAR;
        else if (!load_n)           op = OP_LOAD;
        else if (!enp_n && !ent_n)  op = up ? OP_INC : OP_DEC;
        else                        op = OP_HOLD;
    end
endmodule

// File: rtl/ctr_step.sv
module ctr_step
    import ctr_pkg::*;
#(
    parameter int WIDTH  = 4,
    parameter bit DECADE = 1'b0
) (
    input  logic [WIDTH-1:0] cur,
    input  logic [WIDTH-1:0] din,
    input  ctr_op_e          op,
    output logic [WIDTH-1:0] nxt
);
    localparam int MODULUS = DECADE ? 10 : (1 << WIDTH);
    localparam logic [WIDTH-1:0] LAST = WIDTH'(MODULUS - 1);

    logic at_top;

    generate
        if (DECADE) begin : g_dec
            // values above nine also roll to zero
            assign at_top = (cur >= LAST);
        end else begin : g_bin
            assign at_top = (cur == LAST);
        end
    endgenerate

    always_comb begin
        case (op)
            OP_CLEAR: nxt = '0;
            OP_LOAD:  nxt = din;
            OP_INC:   nxt = at_top ? '0 : cur + 1'b1;
            OP_DEC:   nxt = (cur == '0) ? LAST : cur - 1'b1;
            default:  nxt = cur;
        endcase
    end
endmodule

// File: rtl/ctr_carry.sv
module ctr_carry #(
    parameter int WIDTH  = 4,
    parameter bit DECADE = 1'b0
) (
    input  logic             clk,
    input  logic             arst_n,
    input  logic [WIDTH-1:0] cur,
    input  logic             up,
    input  logic             enp_n,
    input  logic             ent_n,
    output logic             rco_n,
    output logic             cco_n
);
    localparam int MODULUS = DECADE ? 10 : (1 << WIDTH);
    localparam logic [WIDTH-1:0] LAST = WIDTH'(MODULUS - 1);

    logic terminal;

    always_comb begin
        terminal = up ? (cur == LAST) : (cur == '0);
        rco_n    = !(terminal && !ent_n);
        cco_n    = !(!clk && !rco_n && !enp_n);
    end

    // R8: ripple carry never active without the T enable
    a_r8_rco_needs_ent: assert property (@(posedge clk) disable iff (!arst_n)
        !rco_n |-> !ent_n);
    // R9: clocked carry idle whenever P enable is off
    a_r9_cco_idle: assert property (@(posedge clk) disable iff (!arst_n)
        enp_n |-> cco_n);
    // R9: clocked carry never active while the ripple carry is idle
    a_r9_cco_follows_rco: assert property (@(posedge clk) disable iff (!arst_n)
        rco_n |-> cco_n);
endmodule

// File: rtl/updown_counter4.sv
module updown_counter4
    import ctr_pkg::*;
#(
    parameter int WIDTH  = 4,
    parameter bit DECADE = 1'b0
) (
    input  logic             clk,
    input  logic             arst_n,
    input  logic             sclr_n,
    input  logic             load_n,
    input  logic [WIDTH-1:0] din,
    input  logic             enp_n,
    input  logic             ent_n,
    input  logic             up,
    input  logic             oe_n,
    output logic [WIDTH-1:0] q,
    output logic             q_oe,
    output logic             rco_n,
    output logic             cco_n
);
    localparam int MODULUS = DECADE ? 10 : (1 << WIDTH);
    localparam logic [WIDTH-1:0] LAST = WIDTH'(MODULUS - 1);

    typedef struct packed {
        logic [WIDTH-1:0] cnt;
    } state_t;

    state_t          state_d, state_q;
    ctr_op_e         op;
    logic [WIDTH-1:0] step_val;

    ctr_ctrl u_ctrl (
        .sclr_n (sclr_n),
        .load_n (load_n),
        .enp_n  (enp_n),
        .ent_n  (ent_n),
        .up     (up),
        .op     (op)
    );

    ctr_step #(.WIDTH(WIDTH), .DECADE(DECADE)) u_step (
        .cur (state_q.cnt),
        .din (din),
        .op  (op),
        .nxt (step_val)
    );

    ctr_carry #(.WIDTH(WIDTH), .DECADE(DECADE)) u_carry (
        .clk    (clk),
        .arst_n (arst_n),
        .cur    (state_q.cnt),
        .up     (up),
        .enp_n  (enp_n),
        .ent_n  (ent_n),
        .rco_n  (rco_n),
        .cco_n  (cco_n)
    );

    always_comb begin
        state_d     = state_q;
        state_d.cnt = step_val;
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) state_q <= '0;
        else         state_q <= state_d;
    end

    assign q    = state_q.cnt;
    assign q_oe = !oe_n;

    // R1: count held at zero during immediate clear
    a_r1_async_zero: assert property (@(posedge clk) !arst_n |-> q == '0);
    // R2: clear on edge wins over everything synchronous
    a_r2_sclr_zero: assert property (@(posedge clk) disable iff (!arst_n)
        !sclr_n |=> q == '0);
    // R3: preset copies the data bus
    a_r3_load_copy: assert property (@(posedge clk) disable iff (!arst_n)
        (sclr_n && !load_n) |=> q == $past(din));
    // R4: count holds unless both enables are active
    a_r4_hold: assert property (@(posedge clk) disable iff (!arst_n)
        (sclr_n && load_n && (enp_n || ent_n)) |=> $stable(q));
    // R5: one step up with wrap at the range limit
    a_r5_step_up: assert property (@(posedge clk) disable iff (!arst_n)
        (sclr_n && load_n && !enp_n && !ent_n && up) |=>
        q == (($past(q) >= LAST) ? '0 : $past(q) + 1'b1));
    // R5: one step down with wrap at zero
    a_r5_step_down: assert property (@(posedge clk) disable iff (!arst_n)
        (sclr_n && load_n && !enp_n && !ent_n && !up) |=>
        q == (($past(q) == '0) ? LAST : $past(q) - 1'b1));
endmodule

// File: tb/updown_counter4_tb.sv
module updown_counter4_tb;
    localparam time PERIOD = 8ns;

    logic       clk = 1'b0;
    logic       arst_n, sclr_n, load_n, enp_n, ent_n, up, oe_n;
    logic [3:0] din;
    logic [7:0] c_din;
    logic [3:0] q, dq, lo_q, hi_q;
    logic       q_oe, rco_n, cco_n;
    logic       d_oe, d_rco, d_cco, lo_oe, lo_rco, lo_cco, hi_oe, hi_rco, hi_cco;
    int         checks = 0;
    int         fails  = 0;

    always #(PERIOD/2) clk = ~clk;

    updown_counter4 u_dut (
        .clk(clk), .arst_n(arst_n), .sclr_n(sclr_n), .load_n(load_n), .din(din),
        .enp_n(enp_n), .ent_n(ent_n), .up(up), .oe_n(oe_n),
        .q(q), .q_oe(q_oe), .rco_n(rco_n), .cco_n(cco_n));

    updown_counter4 #(.DECADE(1'b1)) u_dec (
        .clk(clk), .arst_n(arst_n), .sclr_n(sclr_n), .load_n(load_n), .din(din),
        .enp_n(enp_n), .ent_n(ent_n), .up(up), .oe_n(oe_n),
        .q(dq), .q_oe(d_oe), .rco_n(d_rco), .cco_n(d_cco));

    updown_counter4 u_lo (
        .clk(clk), .arst_n(arst_n), .sclr_n(sclr_n), .load_n(load_n), .din(c_din[3:0]),
        .enp_n(enp_n), .ent_n(ent_n), .up(up), .oe_n(oe_n),
        .q(lo_q), .q_oe(lo_oe), .rco_n(lo_rco), .cco_n(lo_cco));

    updown_counter4 u_hi (
        .clk(clk), .arst_n(arst_n), .sclr_n(sclr_n), .load_n(load_n), .din(c_din[7:4]),
        .enp_n(enp_n), .ent_n(lo_rco), .up(up), .oe_n(oe_n),
        .q(hi_q), .q_oe(hi_oe), .rco_n(hi_rco), .cco_n(hi_cco));

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // one full clock: from just after a falling edge to just after the next
    task automatic step();
        @(negedge clk);
        #1;
    endtask

    task automatic idle();
        sclr_n = 1'b1; load_n = 1'b1; enp_n = 1'b1; ent_n = 1'b1;
    endtask

    task automatic preset(input logic [3:0] v);
        idle();
        din = v; c_din = {v, v}; load_n = 1'b0;
        step();
        load_n = 1'b1;
    endtask

    task automatic t_reset();
        arst_n = 1'b0; idle(); up = 1'b1; oe_n = 1'b0; din = 4'd7; c_din = 8'h00;
        step(); step();
        check("R1 reset count", q, 0);
        check("R8 reset rco idle", rco_n, 1);
        check("R10 reset drive flag", q_oe, 1);
        arst_n = 1'b1;
        step();
        check("R4 idle after reset", q, 0);
    endtask

    task automatic t_async_clear();
        preset(4'd7);
        check("R3 preset 7", q, 7);
        load_n = 1'b0; din = 4'd3;
        #1 arst_n = 1'b0;
        #1 check("R1 immediate clear", q, 0);
        step();
        check("R1 clear beats load", q, 0);
        arst_n = 1'b1; idle();
        step();
    endtask

    task automatic t_sync_clear();
        preset(4'd5);
        sclr_n = 1'b0; load_n = 1'b0; din = 4'd9; enp_n = 1'b0; ent_n = 1'b0; up = 1'b1;
        #1 check("R2 no change before edge", q, 5);
        step();
        check("R2 clear on edge", q, 0);
        idle();
    endtask

    task automatic t_load_hold();
        preset(4'd10);
        check("R3 preset 10", q, 10);
        load_n = 1'b0; din = 4'd3; enp_n = 1'b0; ent_n = 1'b0; up = 1'b1;
        step();
        check("R3 load beats count", q, 3);
        idle(); enp_n = 1'b1; ent_n = 1'b0;
        step();
        check("R4 hold with P off", q, 3);
        enp_n = 1'b0; ent_n = 1'b1;
        step();
        check("R4 hold with T off", q, 3);
        ent_n = 1'b0;
        step();
        check("R4 step with both on", q, 4);
        idle();
    endtask

    task automatic t_binary_wrap();
        preset(4'd14);
        enp_n = 1'b0; ent_n = 1'b0; up = 1'b1;
        step(); check("R5 up 14->15", q, 15);
        step(); check("R5 up wrap 15->0", q, 0);
        up = 1'b0;
        step(); check("R5 down wrap 0->15", q, 15);
        step(); check("R5 down 15->14", q, 14);
        idle();
    endtask

    task automatic t_decade();
        preset(4'd8);
        enp_n = 1'b0; ent_n = 1'b0; up = 1'b1;
        step(); check("R6 decade up 8->9", dq, 9);
        step(); check("R6 decade wrap 9->0", dq, 0);
        up = 1'b0;
        step(); check("R6 decade wrap 0->9", dq, 9);
        preset(4'd12);
        check("R7 decade accepts 12", dq, 12);
        enp_n = 1'b0; ent_n = 1'b0; up = 1'b1;
        step(); check("R7 decade 12 up ->0", dq, 0);
        preset(4'd13);
        enp_n = 1'b0; ent_n = 1'b0; up = 1'b0;
        step(); check("R7 decade 13 down ->12", dq, 12);
        idle();
    endtask

    task automatic t_rco();
        preset(4'd15);
        up = 1'b1; ent_n = 1'b0;
        #1 check("R8 rco at 15 up", rco_n, 0);
        ent_n = 1'b1;
        #1 check("R8 rco blocked by T", rco_n, 1);
        ent_n = 1'b0; up = 1'b0;
        #1 check("R8 rco 15 down idle", rco_n, 1);
        preset(4'd9);
        up = 1'b1; ent_n = 1'b0;
        #1 check("R8 decade rco at 9 up", d_rco, 0);
        #1 check("R8 binary rco at 9 up", rco_n, 1);
        preset(4'd0);
        up = 1'b0; ent_n = 1'b0;
        #1 check("R8 rco at 0 down", rco_n, 0);
        idle();
    endtask

    task automatic t_cco();
        preset(4'd15);
        up = 1'b1; ent_n = 1'b0; enp_n = 1'b1;
        #1 check("R9 cco idle with P off", cco_n, 1);
        enp_n = 1'b0;
        #1 check("R9 cco active in low phase", cco_n, 0);
        @(posedge clk);
        #1 check("R9 cco idle in high phase", cco_n, 1);
        check("R5 wrapped after carry", q, 0);
        @(negedge clk);
        #1 check("R9 cco idle off terminal", cco_n, 1);
        idle();
    endtask

    task automatic t_oe();
        preset(4'd2);
        oe_n = 1'b1; enp_n = 1'b0; ent_n = 1'b0; up = 1'b1;
        #1 check("R10 drive flag off", q_oe, 0);
        step();
        check("R10 counts while undriven", q, 3);
        oe_n = 1'b0;
        #1 check("R10 drive flag on", q_oe, 1);
        idle();
    endtask

    task automatic t_cascade();
        idle();
        c_din = 8'hFD; load_n = 1'b0;
        step();
        check("R11 cascade preset", {hi_q, lo_q}, 8'hFD);
        idle(); enp_n = 1'b0; ent_n = 1'b0; up = 1'b1;
        for (int i = 1; i <= 5; i++) begin
            step();
            check("R11 cascade up", {hi_q, lo_q}, (8'hFD + i) & 8'hFF);
        end
        up = 1'b0;
        for (int i = 1; i <= 5; i++) begin
            step();
            check("R11 cascade down", {hi_q, lo_q}, (8'h02 - i) & 8'hFF);
        end
        idle();
    endtask

    initial begin
        t_reset();
        t_async_clear();
        t_sync_clear();
        t_load_hold();
        t_binary_wrap();
        t_decade();
        t_rco();
        t_cco();
        t_oe();
        t_cascade();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(PERIOD * 200000);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule